// File: doc/BRIEF.md
# DMA Channel Mode and Command Register Front End

This block is the programming interface of a four-channel DMA controller. Software reaches it through single-cycle I/O write and read strobes carrying an 8-bit data byte and a 4-bit register offset. It keeps a 6-bit mode register for every channel and shows each channel's mode fields on decoded outputs: transfer mode, address direction, autoinit enable and transfer type. Three offsets are command-only. A write to them triggers an action, and the data byte is not used.

The block also keeps one request-mask bit per channel. It masks a channel by itself when that channel's terminal-count pulse arrives, unless the channel autoinitializes. An autoinitializing channel instead raises a one-cycle reload strobe for the outside address and count logic. A byte-pointer flip-flop toggles on every 16-bit register byte access, so that neighbouring address and count registers can pick their low or high byte.

Every channel's mode register is read back through one offset. An internal sequence counter walks channels 0 to 3 on consecutive reads, and the two select bits always read as 11.

Top module: `dma_mode_regs`

## Requirements
- R1: A write to offset 0xB loads the mode register of the channel named by data bits [1:0]. The outputs then show the decoded fields: bits [7:6] transfer mode (00 demand, 01 single, 10 block, 11 cascade), bit 5 direction (1 = decrement), bit 4 autoinit enable, and bits [3:2] transfer type (00 verify, 01 write, 10 read).
- R2: A read strobe at offset 0xB returns, on `rdata` one cycle later, bits [7:2] equal to the mode bits of the channel the sequence counter points to, and bits [1:0] equal to 11.
- R3: Consecutive reads of offset 0xB return channels 0, 1, 2, 3 and then wrap back to channel 0.
- R4: A write to offset 0xE clears all four mask bits and restarts the read sequence at channel 0, whatever the data byte holds.
- R5: `byte_ptr` toggles on each cycle in which `byte_acc` is high, and a write to offset 0xC clears it to 0.
- R6: A write to offset 0xD clears all mode registers, restarts the read sequence, clears `byte_ptr` and sets all four mask bits.
- R7: A terminal-count pulse on a channel whose autoinit bit is 0 sets that channel's mask bit on the next cycle and leaves the other mask bits alone.
- R8: A terminal-count pulse on a channel whose autoinit bit is 1 leaves its mask bit unchanged and raises that channel's `reload` bit for exactly one cycle.
- R9: After reset, every mode field is 0, all mask bits are 1, and `byte_ptr`, `reload` and `rdata` are 0.
- R10: A read strobe at offset 0xC, 0xD or 0xE returns 0 and changes no mask, pointer or read-sequence state.
- R11: When two actions land in the same cycle, the set wins. A terminal count without autoinit beats a clear-all-masks write, and a master clear or a pointer clear beats a `byte_acc` toggle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | I/O write strobe, one cycle |
| rd_en | input | 1 | I/O read strobe, one cycle (ignored while wr_en is high) |
| addr | input | 4 | Register offset |
| wdata | input | 8 | Write data |
| byte_acc | input | 1 | Access to a 16-bit register byte, toggles the pointer |
| tc | input | 4 | Per-channel terminal-count pulse |
| rdata | output | 8 | Registered read data |
| mask | output | 4 | Per-channel request mask |
| byte_ptr | output | 1 | Byte-pointer flip-flop |
| xfer_mode | output | 8 | Transfer mode, 2 bits per channel (channel c at [2c+1:2c]) |
| dir_dec | output | 4 | 1 = decrement addresses, per channel |
| autoinit | output | 4 | Autoinit enable per channel |
| xfer_type | output | 8 | Transfer type, 2 bits per channel (channel c at [2c+1:2c]) |
| reload | output | 4 | One-cycle autoinit reload strobe per channel |

## Verification
Two actions can meet in one cycle. A terminal-count pulse can land in the same cycle as a clear-all-masks write, and a `byte_acc` toggle can land in the same cycle as a master clear. The bench drives both inputs together in one call of its driver task. It then checks that the non-autoinit channel's mask stays set while every other mask bit clears, and that the pointer ends at 0 with all masks set. A read issued after the master clear also confirms that the mode registers and the read sequence were reset.

// File: rtl/dma_mode_pkg.sv
package dma_mode_pkg;
  localparam int ADDR_W = 4;
  localparam int DATA_W = 8;
  localparam int CFG_W  = 6;

  localparam logic [ADDR_W-1:0] OFF_MODE    = 4'hB;
  localparam logic [ADDR_W-1:0] OFF_CLR_PTR = 4'hC;
  localparam logic [ADDR_W-1:0] OFF_MCLR    = 4'hD;
  localparam logic [ADDR_W-1:0] OFF_CLR_MSK = 4'hE;

  typedef enum logic [1:0] {XM_DEMAND, XM_SINGLE, XM_BLOCK, XM_CASCADE} xfer_mode_e;
  typedef enum logic [1:0] {XT_VERIFY, XT_WRITE, XT_READ, XT_RSVD} xfer_type_e;

  typedef struct packed {
    xfer_mode_e mode;
    logic       dec;
    logic       auto_en;
    xfer_type_e ttype;
  } chan_cfg_t;
endpackage

// File: rtl/dma_mode_bank.sv
module dma_mode_bank
  import dma_mode_pkg::*;
#(
  parameter int NCH   = 4,
  parameter int SEL_W = $clog2(NCH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             mclr,
  input  logic             wr_stb,
  input  logic [SEL_W-1:0] sel,
  input  chan_cfg_t        wcfg,
  output chan_cfg_t        cfg [NCH]
);
  for (genvar c = 0; c < NCH; c++) begin : g_ch
    always_ff @(posedge clk) begin
      if (rst || mclr)                         cfg[c] <= '0;
      else if (wr_stb && sel == SEL_W'(c))     cfg[c] <= wcfg;
    end

    // R1: a selected write lands in this channel only
    assert_mode_load_R1: assert property (@(posedge clk) disable iff (rst)
      (wr_stb && !mclr && sel == SEL_W'(c)) |=> cfg[c] == $past(wcfg));
  end
endmodule

// File: rtl/dma_mask_ctl.sv
module dma_mask_ctl #(
  parameter int NCH = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           mclr,
  input  logic           clr_all,
  input  logic [NCH-1:0] tc,
  input  logic [NCH-1:0] auto_en,
  output logic [NCH-1:0] mask,
  output logic [NCH-1:0] reload
);
  for (genvar c = 0; c < NCH; c++) begin : g_ch
    always_ff @(posedge clk) begin
      if (rst || mclr)                mask[c] <= 1'b1;
      else if (tc[c] && !auto_en[c])  mask[c] <= 1'b1;
      else if (clr_all)               mask[c] <= 1'b0;
    end

    always_ff @(posedge clk) begin
      if (rst || mclr) reload[c] <= 1'b0;
      else             reload[c] <= tc[c] && auto_en[c];
    end

    assert_tc_mask_R7: assert property (@(posedge clk) disable iff (rst)
      (tc[c] && !auto_en[c]) |=> mask[c]);

    assert_auto_keep_R8: assert property (@(posedge clk) disable iff (rst)
      (tc[c] && auto_en[c] && !mclr && !clr_all) |=> $stable(mask[c]));

    assert_reload_pulse_R8: assert property (@(posedge clk) disable iff (rst)
      reload[c] |=> (!reload[c] || $past(tc[c])));
  end
endmodule

// File: rtl/dma_rd_seq.sv
module dma_rd_seq
  import dma_mode_pkg::*;
#(
  parameter int NCH   = 4,
  parameter int SEL_W = $clog2(NCH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              restart,
  input  logic              rd_stb,
  input  logic              rd_mode,
  input  chan_cfg_t         cfg [NCH],
  output logic [DATA_W-1:0] rdata
);
  localparam logic [SEL_W-1:0] LAST = SEL_W'(NCH - 1);
  logic [SEL_W-1:0] seq;

  always_ff @(posedge clk) begin
    if (rst || restart)  seq <= '0;
    else if (rd_mode)    seq <= (seq == LAST) ? '0 : seq + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst)          rdata <= '0;
    else if (rd_stb)  rdata <= rd_mode ? {cfg[seq], 2'b11} : '0;
  end

  assert_sel_ones_R2: assert property (@(posedge clk) disable iff (rst)
    rd_mode |=> rdata[1:0] == 2'b11);

  assert_seq_step_R3: assert property (@(posedge clk) disable iff (rst)
    (rd_mode && !restart) |=>
      seq == (($past(seq) == LAST) ? '0 : $past(seq) + 1'b1));

  assert_other_zero_R10: assert property (@(posedge clk) disable iff (rst)
    (rd_stb && !rd_mode) |=> rdata == '0);
endmodule

// File: rtl/dma_mode_regs.sv
module dma_mode_regs
  import dma_mode_pkg::*;
#(
  parameter int NCH = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              byte_acc,
  input  logic [NCH-1:0]    tc,
  output logic [DATA_W-1:0] rdata,
  output logic [NCH-1:0]    mask,
  output logic              byte_ptr,
  output logic [2*NCH-1:0]  xfer_mode,
  output logic [NCH-1:0]    dir_dec,
  output logic [NCH-1:0]    autoinit,
  output logic [2*NCH-1:0]  xfer_type,
  output logic [NCH-1:0]    reload
);
  localparam int SEL_W = $clog2(NCH);

  logic      mode_wr, clr_ptr, mclr, clr_msk, rd_stb, rd_mode;
  chan_cfg_t cfg [NCH];

  assign mode_wr = wr_en && addr == OFF_MODE;
  assign clr_ptr = wr_en && addr == OFF_CLR_PTR;
  assign mclr    = wr_en && addr == OFF_MCLR;
  assign clr_msk = wr_en && addr == OFF_CLR_MSK;
  assign rd_stb  = rd_en && !wr_en;
  assign rd_mode = rd_stb && addr == OFF_MODE;

  dma_mode_bank #(.NCH(NCH), .SEL_W(SEL_W)) bank_i (
    .clk(clk), .rst(rst), .mclr(mclr), .wr_stb(mode_wr),
    .sel(wdata[SEL_W-1:0]), .wcfg(chan_cfg_t'(wdata[DATA_W-1:2])), .cfg(cfg)
  );

  dma_mask_ctl #(.NCH(NCH)) mask_i (
    .clk(clk), .rst(rst), .mclr(mclr), .clr_all(clr_msk),
    .tc(tc), .auto_en(autoinit), .mask(mask), .reload(reload)
  );

  dma_rd_seq #(.NCH(NCH), .SEL_W(SEL_W)) seq_i (
    .clk(clk), .rst(rst), .restart(mclr || clr_msk),
    .rd_stb(rd_stb), .rd_mode(rd_mode), .cfg(cfg), .rdata(rdata)
  );

  always_ff @(posedge clk) begin
    if (rst || mclr || clr_ptr) byte_ptr <= 1'b0;
    else if (byte_acc)          byte_ptr <= ~byte_ptr;
  end

  for (genvar c = 0; c < NCH; c++) begin : g_out
    assign xfer_mode[2*c +: 2] = cfg[c].mode;
    assign dir_dec[c]          = cfg[c].dec;
    assign autoinit[c]         = cfg[c].auto_en;
    assign xfer_type[2*c +: 2] = cfg[c].ttype;
  end

  assert_ptr_toggle_R5: assert property (@(posedge clk) disable iff (rst)
    (byte_acc && !clr_ptr && !mclr) |=> byte_ptr != $past(byte_ptr));

  assert_mclr_state_R6: assert property (@(posedge clk) disable iff (rst)
    mclr |=> (&mask && !byte_ptr && autoinit == '0));

  assert_clr_wins_R11: assert property (@(posedge clk) disable iff (rst)
    (byte_acc && (mclr || clr_ptr)) |=> !byte_ptr);
endmodule

// File: tb/dma_mode_regs_tb_top.sv
module dma_mode_regs_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0, rd_en = 1'b0, byte_acc = 1'b0;
  logic [3:0] addr = '0, tc = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata, xfer_mode, xfer_type;
  logic [3:0] mask, dir_dec, autoinit, reload;
  logic       byte_ptr;

  int checks = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  dma_mode_regs dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .byte_acc(byte_acc), .tc(tc), .rdata(rdata), .mask(mask),
    .byte_ptr(byte_ptr), .xfer_mode(xfer_mode), .dir_dec(dir_dec),
    .autoinit(autoinit), .xfer_type(xfer_type), .reload(reload)
  );

  // bench model
  logic [5:0] m_cfg [4];
  int         m_seq = 0;
  logic [7:0] exp_q [$];
  string      tag_q [$];
  logic       pend = 1'b0;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: a read strobe seen at a rising edge has its data at the next falling edge
  always @(posedge clk) pend <= rd_en && !wr_en;
  always @(negedge clk) begin
    if (pend && exp_q.size() > 0) begin
      automatic logic [7:0] e = exp_q.pop_front();
      automatic string      t = tag_q.pop_front();
      chk(t, {24'd0, rdata}, {24'd0, e});
    end
  end

  task automatic wr(logic [3:0] a, logic [7:0] d, logic [3:0] tcv = 4'h0, logic ba = 1'b0);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d; tc = tcv; byte_acc = ba;
    if (a == 4'hB) m_cfg[d[1:0]] = d[7:2];
    if (a == 4'hD) begin
      for (int i = 0; i < 4; i++) m_cfg[i] = '0;
      m_seq = 0;
    end
    if (a == 4'hE) m_seq = 0;
    @(negedge clk);
    wr_en = 1'b0; tc = '0; byte_acc = 1'b0;
  endtask

  task automatic rd(logic [3:0] a, string t);
    @(negedge clk);
    if (a == 4'hB) begin
      exp_q.push_back({m_cfg[m_seq], 2'b11});
      m_seq = (m_seq + 1) % 4;
    end else exp_q.push_back(8'h00);
    tag_q.push_back(t);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic pulse(logic [3:0] tcv, logic ba);
    @(negedge clk);
    tc = tcv; byte_acc = ba;
    @(negedge clk);
    tc = '0; byte_acc = 1'b0;
  endtask

  initial begin
    for (int i = 0; i < 4; i++) m_cfg[i] = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R9 reset state
    chk("R9 mask", mask, 4'hF);
    chk("R9 ptr", byte_ptr, 0);
    chk("R9 modes", {xfer_mode, xfer_type, dir_dec, autoinit}, 0);
    chk("R9 reload/rdata", {reload, rdata}, 0);

    // R1 mode writes, out of channel order
    wr(4'hB, 8'hC2); // ch2: cascade, inc, no auto, verify
    wr(4'hB, 8'hB8); // ch0: block, dec, auto, read
    wr(4'hB, 8'h2B); // ch3: demand, dec, no auto, read
    wr(4'hB, 8'h45); // ch1: single, inc, no auto, write
    chk("R1 xfer_mode", xfer_mode, 8'b00_11_01_10);
    chk("R1 xfer_type", xfer_type, 8'b10_00_01_10);
    chk("R1 dir_dec", dir_dec, 4'b1001);
    chk("R1 autoinit", autoinit, 4'b0001);

    // R2/R3 readback sequence with wrap
    rd(4'hB, "R2 ch0");
    rd(4'hB, "R3 ch1");
    rd(4'hB, "R3 ch2");
    rd(4'hB, "R3 ch3");
    rd(4'hB, "R3 wrap ch0");

    // R4 clear masks restarts sequence (data byte ignored)
    wr(4'hE, 8'hFF);
    chk("R4 masks cleared", mask, 4'h0);
    rd(4'hB, "R4 seq restart ch0");

    // R10 reads of command offsets
    rd(4'hC, "R10 read 0xC");
    rd(4'hD, "R10 read 0xD");
    rd(4'hE, "R10 read 0xE");
    chk("R10 mask unchanged", mask, 4'h0);
    chk("R10 ptr unchanged", byte_ptr, 0);
    rd(4'hB, "R10 seq unchanged ch1");

    // R5 pointer toggle and clear
    pulse(4'h0, 1'b1);
    chk("R5 toggle 1", byte_ptr, 1);
    pulse(4'h0, 1'b1);
    pulse(4'h0, 1'b1);
    chk("R5 toggle 3", byte_ptr, 1);
    wr(4'hC, 8'hA5);
    chk("R5 clear", byte_ptr, 0);

    // R7 terminal count without autoinit
    pulse(4'b0010, 1'b0);
    chk("R7 mask ch1", mask, 4'b0010);
    chk("R7 no reload", reload, 4'h0);

    // R8 terminal count with autoinit: reload is high at the first sample, then low
    @(negedge clk);
    tc = 4'b0001;
    @(negedge clk);
    tc = '0;
    chk("R8 reload pulse", reload, 4'b0001);
    chk("R8 mask kept", mask, 4'b0010);
    @(negedge clk);
    chk("R8 reload one cycle", reload, 4'h0);

    // R11 clear-all-masks meets terminal count on ch3 (no autoinit)
    wr(4'hE, 8'h00, 4'b1000, 1'b0);
    chk("R11 tc beats clear", mask, 4'b1000);

    // R6 master clear meets byte_acc (R11)
    pulse(4'h0, 1'b1);
    chk("R5 ptr set before mclr", byte_ptr, 1);
    wr(4'hE, 8'h00);
    wr(4'hD, 8'h5A, 4'h0, 1'b1);
    chk("R11 mclr beats toggle", byte_ptr, 0);
    chk("R6 masks set", mask, 4'hF);
    chk("R6 modes cleared", {xfer_mode, xfer_type, dir_dec, autoinit}, 0);
    rd(4'hB, "R6 cleared ch0");
    rd(4'hB, "R6 cleared ch1");

    repeat (3) @(negedge clk);
    chk("scoreboard drained", exp_q.size(), 0);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule